// File: doc/BRIEF.md
# Converter Clock-Gate and Sleep Sequencer

This block drives the conversion clock and the power-down line of a sampling analog-to-digital converter from a free-running clock at twice the conversion rate. It divides that clock by two with a toggle flop. It stops the divided clock only after a whole period has completed, and parks it low. It powers the converter down only after the clock has stopped and no conversion is in progress. When the converter is woken it counts out a settling time before it raises a ready flag.

After reset the sequencer holds an active-low recalibration line for a fixed number of conversion-clock periods, with the clock running. It then reports ready. A sleep request is a single-cycle pulse that is remembered until it can be served. A start pulse wakes the converter out of power-down. Once settling has elapsed, any conversion that is still busy gets clocks until it finishes, followed by an input-acquisition window of whole periods. Settling lengths are derived from the input clock frequency and rounded up to whole cycles. The defaults are 3400 kHz, with 3.2 µs giving 11 cycles and 20 µs giving 68 cycles.

Top module: `adcs_sleep_seq`

## Requirements
- R1: While reset is held, and for 8 double-rate cycles (4 conversion periods) after it is released, `recal_n` is low, `shdn_n` is high and `ready` is low, while `cclk` toggles on every double-rate edge. In the cycle after that, `recal_n` and `ready` are both high.
- R2: A high phase of `cclk` always lasts exactly one double-rate cycle. The clock only freezes in the low state, so no shortened phase is ever produced.
- R3: `shdn_n` goes low only when `cclk` was low on the previous cycle. While `shdn_n` is low, `cclk` stays low.
- R4: While `conv_busy` is high, a pending sleep request is not served: `ready` and `shdn_n` stay high and `cclk` keeps toggling.
- R5: Once a sleep request can be served, the sequencer stops the clock and drops `shdn_n`. This happens 2 cycles after the serving edge if `cclk` was low after that edge, and 3 cycles after it otherwise.
- R6: In power-down, a `start_req` pulse raises `shdn_n` at the next edge, with `ready` low. `ready` rises S+8 cycles after that edge, where S is 11 when `fine_settle` is 0 and 68 when it is 1, with `fine_settle` sampled while powered down.
- R7: If `conv_busy` is high when settling ends, `cclk` keeps running and `ready` stays low. `ready` then rises exactly 8 cycles after `conv_busy` is first seen low.
- R8: A sleep pulse that arrives during recalibration or wake-up is held. `ready` is reported and the shutdown then follows without a new request.
- R9: `start_req` has no effect outside power-down. A `sleep_req` pulse during power-down is discarded, so it does not send the converter back to sleep after the next wake-up.
- R10: `ready` is high only when `shdn_n` and `recal_n` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Free-running clock at twice the conversion rate |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | One-cycle request to power the converter down |
| conv_busy | input | 1 | Converter reports a conversion in progress |
| start_req | input | 1 | One-cycle request to wake the converter |
| fine_settle | input | 1 | 0 selects the short settle, 1 the long settle |
| cclk | output | 1 | Divided conversion clock |
| shdn_n | output | 1 | Active-low power-down to the converter |
| recal_n | output | 1 | Active-low recalibration pulse |
| ready | output | 1 | Converter is awake, settled and may convert |

## Verification
The bench targets the stop boundary. A divider that froze mid-period would leave `cclk` high for two cycles or high while `shdn_n` is low. A sequencer that powered down before parking would drop `shdn_n` with the clock just high. It also drives `conv_busy` across a sleep request and through the end of settling. A design that ignored it would cut power mid-conversion, or raise `ready` before the eight-cycle acquisition window. Exact wake latencies for both settle selections expose an off-by-one in the rounded counts. Sleep pulses placed in settling and in power-down show whether a request is wrongly dropped or wrongly kept.

// File: rtl/adcs_pkg.sv
// Shared types and helpers for the converter sleep sequencer.
// Assumes all timing is counted in cycles of the double-rate input clock.
package adcs_pkg;

    typedef enum logic [2:0] {
        ST_RECAL  = 3'd0,
        ST_RUN    = 3'd1,
        ST_HALT   = 3'd2,
        ST_OFF    = 3'd3,
        ST_SETTLE = 3'd4,
        ST_ACQ    = 3'd5
    } seq_state_t;

    // Nanoseconds to whole input-clock cycles, rounded up.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned khz);
        longint unsigned prod;
        prod = longint'(ns) * longint'(khz);
        return int'((prod + 64'd999999) / 64'd1000000);
    endfunction

endpackage

// File: rtl/adcs_clk_toggle.sv
// Divide-by-two conversion clock generator.
// The flop toggles while run_en is high. It also completes any high phase
// already in progress, so it always freezes low after a full period.
// Assumes the caller deasserts run_en to request a stop.
module adcs_clk_toggle (
    input  logic clk2x,
    input  logic rst_n,
    input  logic run_en,
    output logic cclk,
    output logic parked
);

    logic cclk_q;

    // Toggle stage: runs on request, or to finish a high phase.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            cclk_q <= 1'b0;
        end else if (run_en || cclk_q) begin
            cclk_q <= ~cclk_q;
        end
    end

    assign cclk   = cclk_q;
    assign parked = !run_en && !cclk_q;

endmodule

// File: rtl/adcs_dwell.sv
// Dwell counter for the timed sequencer states.
// It counts advancing cycles from zero and flags the last cycle of a
// window of 'limit' cycles. Assumes limit >= 1.
module adcs_dwell #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk2x,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Count the cycles spent in the current timed state.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == (limit - 1'b1));

endmodule

// File: rtl/adcs_ctrl.sv
// Sequencer state machine.
// Order of events: recalibrate -> run -> park the clock -> power down ->
// settle -> finish any busy conversion and acquire -> run.
// Assumes sleep_req and start_req are single-cycle pulses.
module adcs_ctrl
    import adcs_pkg::*;
#(
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned RECAL_CYC  = 8,
    parameter int unsigned ACQ_CYC    = 8,
    parameter int unsigned COARSE_CYC = 11,
    parameter int unsigned FINE_CYC   = 68
) (
    input  logic             clk2x,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             conv_busy,
    input  logic             start_req,
    input  logic             fine_settle,
    input  logic             clk_parked,
    input  logic             dwell_done,
    output logic             dwell_clr,
    output logic             dwell_adv,
    output logic [CNT_W-1:0] dwell_limit,
    output logic             run_en,
    output logic             shdn_n,
    output logic             recal_n,
    output logic             ready
);

    seq_state_t state_q, state_d;
    logic       sleep_pend_q;
    logic       fine_q;
    logic       sleep_want;

    assign sleep_want = sleep_pend_q || sleep_req;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RECAL:  if (dwell_done) state_d = ST_RUN;
            ST_RUN:    if (sleep_want && !conv_busy) state_d = ST_HALT;
            ST_HALT:   if (clk_parked) state_d = ST_OFF;
            ST_OFF:    if (start_req) state_d = ST_SETTLE;
            ST_SETTLE: if (dwell_done) state_d = ST_ACQ;
            ST_ACQ:    if (dwell_done && !conv_busy) state_d = ST_RUN;
            default:   state_d = ST_RECAL;
        endcase
    end

    // State register.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            state_q <= ST_RECAL;
        end else begin
            state_q <= state_d;
        end
    end

    // Hold a sleep pulse until it is served; drop pulses seen while parked or off.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            sleep_pend_q <= 1'b0;
        end else if (state_q == ST_HALT || state_q == ST_OFF) begin
            sleep_pend_q <= 1'b0;
        end else if (sleep_req) begin
            sleep_pend_q <= 1'b1;
        end
    end

    // Sample the settle-length select while powered down.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            fine_q <= 1'b0;
        end else if (state_q == ST_OFF) begin
            fine_q <= fine_settle;
        end
    end

    // Dwell window for each timed state.
    always_comb begin
        case (state_q)
            ST_RECAL:  dwell_limit = CNT_W'(RECAL_CYC);
            ST_SETTLE: dwell_limit = fine_q ? CNT_W'(FINE_CYC) : CNT_W'(COARSE_CYC);
            ST_ACQ:    dwell_limit = CNT_W'(ACQ_CYC);
            default:   dwell_limit = CNT_W'(RECAL_CYC);
        endcase
    end

    // Restart the dwell on each state change, and hold acquisition at zero while busy.
    assign dwell_clr = (state_d != state_q) || (state_q == ST_ACQ && conv_busy);
    assign dwell_adv = (state_q == ST_RECAL) || (state_q == ST_SETTLE) ||
                       (state_q == ST_ACQ);

    // Output decode from the state register.
    assign run_en  = (state_q == ST_RECAL) || (state_q == ST_RUN) ||
                     (state_q == ST_SETTLE) || (state_q == ST_ACQ);
    assign shdn_n  = (state_q != ST_OFF);
    assign recal_n = (state_q != ST_RECAL);
    assign ready   = (state_q == ST_RUN);

endmodule

// File: rtl/adcs_sleep_seq.sv
// Top level of the converter clock-gate and sleep sequencer.
// Derives every cycle count from the input clock frequency and the
// requested times, then wires the divider, dwell counter and state machine.
// Assumes clk2x is free running at CLK_KHZ and rst_n is synchronous.
module adcs_sleep_seq
    import adcs_pkg::*;
#(
    parameter int unsigned CLK_KHZ       = 3400,
    parameter int unsigned COARSE_NS     = 3200,
    parameter int unsigned FINE_NS       = 20000,
    parameter int unsigned RECAL_PERIODS = 4,
    parameter int unsigned ACQ_PERIODS   = 4
) (
    input  logic clk2x,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic conv_busy,
    input  logic start_req,
    input  logic fine_settle,
    output logic cclk,
    output logic shdn_n,
    output logic recal_n,
    output logic ready
);

    localparam int unsigned COARSE_CYC = ns_to_cycles(COARSE_NS, CLK_KHZ);
    localparam int unsigned FINE_CYC   = ns_to_cycles(FINE_NS, CLK_KHZ);
    localparam int unsigned RECAL_CYC  = 2 * RECAL_PERIODS;
    localparam int unsigned ACQ_CYC    = 2 * ACQ_PERIODS;
    localparam int unsigned MAX_A      = (COARSE_CYC > FINE_CYC) ? COARSE_CYC : FINE_CYC;
    localparam int unsigned MAX_B      = (RECAL_CYC > ACQ_CYC) ? RECAL_CYC : ACQ_CYC;
    localparam int unsigned MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

    logic             run_en;
    logic             clk_parked;
    logic             dwell_clr;
    logic             dwell_adv;
    logic             dwell_done;
    logic [CNT_W-1:0] dwell_limit;

    adcs_clk_toggle u_div (
        .clk2x  (clk2x),
        .rst_n  (rst_n),
        .run_en (run_en),
        .cclk   (cclk),
        .parked (clk_parked)
    );

    adcs_dwell #(
        .CNT_W (CNT_W)
    ) u_dwell (
        .clk2x (clk2x),
        .rst_n (rst_n),
        .clr   (dwell_clr),
        .adv   (dwell_adv),
        .limit (dwell_limit),
        .done  (dwell_done)
    );

    adcs_ctrl #(
        .CNT_W      (CNT_W),
        .RECAL_CYC  (RECAL_CYC),
        .ACQ_CYC    (ACQ_CYC),
        .COARSE_CYC (COARSE_CYC),
        .FINE_CYC   (FINE_CYC)
    ) u_ctrl (
        .clk2x       (clk2x),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .conv_busy   (conv_busy),
        .start_req   (start_req),
        .fine_settle (fine_settle),
        .clk_parked  (clk_parked),
        .dwell_done  (dwell_done),
        .dwell_clr   (dwell_clr),
        .dwell_adv   (dwell_adv),
        .dwell_limit (dwell_limit),
        .run_en      (run_en),
        .shdn_n      (shdn_n),
        .recal_n     (recal_n),
        .ready       (ready)
    );

endmodule

// File: rtl/adcs_sleep_seq_chk.sv
// Port-level protocol checks for the sleep sequencer, bound to the top.
module adcs_sleep_seq_chk (
    input logic clk2x,
    input logic rst_n,
    input logic conv_busy,
    input logic cclk,
    input logic shdn_n,
    input logic recal_n,
    input logic ready
);

    p_recal_clk_r1: assert property (@(posedge clk2x) disable iff (!rst_n)
        !recal_n |=> (cclk != $past(cclk)));

    p_high_one_r2: assert property (@(posedge clk2x) disable iff (!rst_n)
        cclk |=> !cclk);

    p_off_low_r3: assert property (@(posedge clk2x) disable iff (!rst_n)
        !shdn_n |-> !cclk);

    p_fall_parked_r3: assert property (@(posedge clk2x) disable iff (!rst_n)
        $fell(shdn_n) |-> !$past(cclk));

    p_busy_hold_r4: assert property (@(posedge clk2x) disable iff (!rst_n)
        (ready && conv_busy) |=> (shdn_n && (cclk != $past(cclk))));

    p_wake_low_r6: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(shdn_n) |-> (!ready && recal_n));

    p_ready_ok_r10: assert property (@(posedge clk2x) disable iff (!rst_n)
        ready |-> (shdn_n && recal_n));

endmodule

bind adcs_sleep_seq adcs_sleep_seq_chk u_chk (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .conv_busy (conv_busy),
    .cclk      (cclk),
    .shdn_n    (shdn_n),
    .recal_n   (recal_n),
    .ready     (ready)
);

// File: tb/adcs_sleep_seq_bench.sv
module adcs_sleep_seq_bench;

    logic clk2x = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic conv_busy = 1'b0;
    logic start_req = 1'b0;
    logic fine_settle = 1'b0;
    logic cclk, shdn_n, recal_n, ready;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic armed = 1'b0;
    logic prev_cclk = 1'b0;
    logic prev_shdn = 1'b1;

    always #4 clk2x = ~clk2x;

    adcs_sleep_seq u_adcs_sleep_seq (
        .clk2x       (clk2x),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .conv_busy   (conv_busy),
        .start_req   (start_req),
        .fine_settle (fine_settle),
        .cclk        (cclk),
        .shdn_n      (shdn_n),
        .recal_n     (recal_n),
        .ready       (ready)
    );

    function automatic int settle_cycles(input logic fine);
        longint unsigned ns = fine ? 64'd20000 : 64'd3200;
        return int'((ns * 64'd3400 + 64'd999999) / 64'd1000000);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Invariant monitor, sampled one time unit after each edge.
    task automatic monitor();
        if (armed && rst_n) begin
            if (prev_cclk) check(!cclk, "R2 high phase length", cclk, 0);
            if (!shdn_n) check(!cclk, "R3 clock low in power-down", cclk, 0);
            if (prev_shdn && !shdn_n) check(!prev_cclk, "R3 parked before power-down", prev_cclk, 0);
            if (!prev_shdn && shdn_n) check(!ready, "R6 not ready at wake", ready, 0);
            if (ready) check(shdn_n && recal_n, "R10 ready qualifiers", {shdn_n, recal_n}, 3);
        end
        armed = rst_n;
        prev_cclk = cclk;
        prev_shdn = shdn_n;
    endtask

    task automatic tick();
        @(posedge clk2x);
        #1;
        monitor();
    endtask

    // Count ticks until ready is high, up to a bound.
    task automatic ticks_to_ready(output int n);
        n = 0;
        while (!ready && n < 400) begin
            tick();
            n++;
        end
    endtask

    task automatic go_to_sleep();
        int n = 0;
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        while (shdn_n && n < 50) begin
            tick();
            n++;
        end
        check(!shdn_n, "R5 reached power-down", shdn_n, 0);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk2x) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    initial begin
        int n;
        logic c1;
        logic pc;
        void'($urandom(32'h1c3a5));

        // Reset state (R1).
        repeat (3) tick();
        check(!recal_n && shdn_n && !ready && !cclk, "R1 reset outputs",
              {recal_n, shdn_n, ready, cclk}, 4);
        rst_n = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            tick();
            check(cclk == k[0], "R1 clock runs in recal", cclk, k[0]);
            if (k < 8) check(!recal_n && !ready, "R1 recal held", recal_n, 0);
            else check(recal_n && ready, "R1 ready after recal", {recal_n, ready}, 3);
        end

        // Busy blocks sleep (R4), then exact park latency (R5).
        conv_busy = 1'b1;
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        for (int k = 0; k < 6; k++) begin
            pc = cclk;
            tick();
            check(shdn_n && ready && (cclk != pc), "R4 busy keeps running",
                  {shdn_n, ready}, 3);
        end
        conv_busy = 1'b0;
        tick();
        c1 = cclk;
        n = 1;
        while (shdn_n && n < 10) begin
            tick();
            n++;
        end
        check(n == (c1 ? 3 : 2), "R5 power-down latency", n, c1 ? 3 : 2);

        // Sleep pulse while off is discarded (R9).
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        repeat (5) tick();
        check(!shdn_n && !cclk && !ready, "R9 stays off", shdn_n, 0);

        // Coarse wake (R6).
        fine_settle = 1'b0;
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        check(shdn_n && !ready, "R6 wake edge", {shdn_n, ready}, 2);
        ticks_to_ready(n);
        check(n == settle_cycles(1'b0) + 8, "R6 coarse wake latency", n, settle_cycles(1'b0) + 8);

        // Stale sleep pulse must not re-sleep; start in run ignored (R9).
        start_req = 1'b1;
        repeat (3) tick();
        start_req = 1'b0;
        for (int k = 0; k < 10; k++) begin
            tick();
            check(ready && shdn_n, "R9 no effect while running", ready, 1);
        end

        // Fine wake (R6).
        go_to_sleep();
        fine_settle = 1'b1;
        repeat (2) tick();
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        fine_settle = 1'b0;
        ticks_to_ready(n);
        check(n == settle_cycles(1'b1) + 8, "R6 fine wake latency", n, settle_cycles(1'b1) + 8);

        // Busy across end of settle (R7).
        go_to_sleep();
        conv_busy = 1'b1;
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        for (int k = 0; k < 30; k++) begin
            pc = cclk;
            tick();
            check(!ready && (cclk != pc), "R7 clocks while busy", ready, 0);
        end
        conv_busy = 1'b0;
        ticks_to_ready(n);
        check(n == 8, "R7 acquisition window", n, 8);

        // Sleep held through settling (R8).
        go_to_sleep();
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        repeat (3) tick();
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        ticks_to_ready(n);
        check(ready, "R8 ready reported", ready, 1);
        n = 0;
        while (shdn_n && n < 10) begin
            tick();
            n++;
        end
        check(!shdn_n, "R8 held sleep served", shdn_n, 0);

        // Random mix; invariants checked by the monitor (R2 R3 R6 R10).
        for (int k = 0; k < 3000; k++) begin
            sleep_req = ($urandom % 16) == 0;
            start_req = ($urandom % 10) == 0;
            fine_settle = $urandom % 2;
            if (($urandom % 12) == 0) conv_busy = ~conv_busy;
            tick();
        end
        sleep_req = 1'b0;
        start_req = 1'b0;
        conv_busy = 1'b0;
        repeat (4) tick();
        summary();
    end

endmodule